// File: doc/BRIEF.md
# Serial Mode-Control Register Port

This block is a serial slave that lets a host configure a converter's mode-control settings over a four-wire link. The wires are an active-low select, a serial clock, a data input, and a data output that can only pull the line low. Every transaction is a 16-bit frame sent most significant bit first. The first bit says whether the frame reads or writes. The next seven bits carry the register address, and the last eight bits carry the register byte.

The block stores four configuration bytes and decodes them into plain control pins. Those pins set the sample format, the clock duty-cycle stabilizer, the output randomizer, the per-channel nap and sleep states, the output driver code, the lane count and a 16-bit test pattern. Address 00h holds a write-only reset command. Setting its top bit clears every configuration byte and sends a short sleep request to the converter.

The serial pins are oversampled by the system clock. The host sets the bit rate, so the link has no valid/ready handshake and no back-pressure. The host must only keep each SCK phase long enough for the synchronizers to see it. The decoded outputs are level signals that change one clock after a write is committed.

Top module: `ctlreg_spi_top`

## Requirements
- R1: A frame is 16 bits, sampled on SCK rising edges while cs_n is low, most significant bit first. Frame bit 0 is the direction flag (0 = write, 1 = read). Frame bits 1..7 are address A6..A0, and frame bits 8..15 are data D7..D0.
- R2: A write frame updates the addressed register when the 16th SCK rising edge is detected. The stored bytes are at 01h (format/power), 02h (output mode), 03h (pattern high byte) and 04h (pattern low byte).
- R3: In a read frame, the addressed byte appears on the data output during frame bits 8..15, MSB first. Each bit changes after an SCK falling edge. The read changes no register, and the data-input bits of that frame are ignored.
- R4: The data output is open-drain. sdo_oe=1 means the line is pulled low (bit value 0), and sdo_oe=0 releases it (bit value 1). sdo_oe is 0 whenever cs_n is high and outside the data phase of a read frame.
- R5: If cs_n rises before the 16th SCK rising edge, the frame is dropped and no register changes.
- R6: A write to address 00h with D7=1 clears bytes 01h..04h to 00h. A write to 00h with D7=0 has no effect. A read of 00h returns a value that is not specified.
- R7: Each software-reset write drives sw_sleep_pulse high for exactly SLP_CYCLES system clocks (4 by default).
- R8: Register 01h decodes as follows:
  - bit 7 drives dcs_off, bit 6 drives rand_en, and bit 5 drives twos_comp (1 = two's complement, 0 = offset binary).
  - bit 4 is SLEEP, bit 3 is NAP_2 and bit 0 is NAP_1.
  - SLEEP=1 sets sleep_mode and forces both nap outputs to 0.
  - Otherwise nap_ch1 follows NAP_1 and nap_ch2 follows NAP_2, each on its own.
- R9: Register 02h decodes as follows:
  - bits 7..5 drive drv_code, bit 4 drives term_en, bit 3 drives out_disable and bit 2 drives test_pat_en.
  - bits 1..0 drive lane_sel and lane_onehot = {4-lane, 2-lane, 1-lane}. Code 00 gives 010, code 01 gives 100, code 10 gives 001, and the reserved code 11 gives 000.
- R10: test_pattern equals {byte 03h, byte 04h}.
- R11: Addresses 05h..7Fh read as 00h, and writes to them change nothing.
- R12: When rst_n is low, all stored bytes are 00h, sleep_mode and sw_sleep_pulse are 0, and sdo_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data from the host |
| sdo_oe | output | 1 | 1 = pull the data line low; 0 = release it |
| dcs_off | output | 1 | Duty-cycle stabilizer disabled |
| rand_en | output | 1 | Output randomizer enabled |
| twos_comp | output | 1 | Two's complement sample format |
| sleep_mode | output | 1 | Both channels disabled |
| nap_ch1 | output | 1 | Channel 1 in nap |
| nap_ch2 | output | 1 | Channel 2 in nap |
| sw_sleep_pulse | output | 1 | Short sleep request after a software reset |
| drv_code | output | 3 | Output driver current code |
| term_en | output | 1 | Internal termination enable |
| out_disable | output | 1 | Digital outputs disabled |
| test_pat_en | output | 1 | Test pattern replaces sample data |
| lane_sel | output | 2 | Raw lane mode code |
| lane_onehot | output | 3 | Decoded lanes {4,2,1}; 000 for the reserved code |
| test_pattern | output | 16 | Test pattern word |

## Verification
The assertions assume the following about the serial inputs:
- SCK idles low.
- Each SCK high or low phase lasts well beyond the synchronizer depth plus two system clocks.
- cs_n changes only while SCK is low.

Under these conditions every edge is seen exactly once and the SDO bit is settled before the next rising edge. The stimulus holds each SCK phase for eight system clocks, changes data and select only while SCK is low, and drives all pins on the falling edge of the system clock.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int FRAME_BITS = 16;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int NUM_CFG    = 4;   // stored bytes at addresses 1..NUM_CFG

  localparam logic [ADDR_W-1:0] ADR_SWRST = 7'h00;
  localparam logic [ADDR_W-1:0] ADR_FMT   = 7'h01;
  localparam logic [ADDR_W-1:0] ADR_OMODE = 7'h02;
  localparam logic [ADDR_W-1:0] ADR_TPHI  = 7'h03;
  localparam logic [ADDR_W-1:0] ADR_TPLO  = 7'h04;

  // format/power byte bit positions
  localparam int FMT_DCS   = 7;
  localparam int FMT_RAND  = 6;
  localparam int FMT_TWOS  = 5;
  localparam int FMT_SLEEP = 4;
  localparam int FMT_NAP2  = 3;
  localparam int FMT_NAP1  = 0;

  // output-mode byte bit positions
  localparam int OM_DRV_LSB = 5;
  localparam int OM_TERM    = 4;
  localparam int OM_OFF     = 3;
  localparam int OM_TEST    = 2;

  typedef enum logic [1:0] {
    LANES_TWO  = 2'b00,
    LANES_FOUR = 2'b01,
    LANES_ONE  = 2'b10,
    LANES_RSVD = 2'b11
  } lane_code_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import ctlreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NBITS       = FRAME_BITS,
  parameter int AW          = ADDR_W,
  parameter int DW          = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          sdi,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_valid,
  output wr_req_t       wr_req,
  output logic          sdo_oe
);
  localparam int CNT_W = $clog2(NBITS + 1);
  localparam int HDR   = AW + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NBITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBITS);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR);

  logic [SYNC_STAGES-1:0] cs_sync, sck_sync, sdi_sync;
  logic sck_q;
  logic cs_act, sck_s, sdi_s, rise, fall;
  logic [CNT_W-1:0] bit_cnt;
  logic [NBITS-1:0] shreg;
  logic [DW-1:0]    rd_latch;
  logic             rd_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync  <= '1;
      sck_sync <= '0;
      sdi_sync <= '0;
      sck_q    <= 1'b0;
    end else begin
      cs_sync  <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], sck};
      sdi_sync <= {sdi_sync[SYNC_STAGES-2:0], sdi};
      sck_q    <= sck_sync[SYNC_STAGES-1];
    end
  end

  assign cs_act = ~cs_sync[SYNC_STAGES-1];
  assign sck_s  = sck_sync[SYNC_STAGES-1];
  assign sdi_s  = sdi_sync[SYNC_STAGES-1];
  assign rise   = cs_act &  sck_s & ~sck_q;
  assign fall   = cs_act & ~sck_s &  sck_q;

  // header is complete once HDR bits are in: address sits in the low bits
  assign rd_addr = shreg[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      wr_valid <= 1'b0;
      wr_req   <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
      end else if (rise && bit_cnt < CNT_FULL) begin
        shreg   <= {shreg[NBITS-2:0], sdi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_LAST && !shreg[NBITS-2]) begin
          wr_valid    <= 1'b1;
          wr_req.addr <= shreg[NBITS-3 -: AW];
          wr_req.data <= {shreg[DW-2:0], sdi_s};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_oe   <= 1'b0;
      rd_frame <= 1'b0;
      rd_latch <= '0;
    end else if (!cs_act) begin
      sdo_oe   <= 1'b0;
      rd_frame <= 1'b0;
    end else if (fall) begin
      if (bit_cnt == CNT_HDR && shreg[AW]) begin
        rd_frame <= 1'b1;
        rd_latch <= rd_data;
        sdo_oe   <= ~rd_data[DW-1];
      end else if (rd_frame && bit_cnt > CNT_HDR && bit_cnt < CNT_FULL) begin
        rd_latch <= {rd_latch[DW-2:0], 1'b0};
        sdo_oe   <= ~rd_latch[DW-2];
      end else begin
        sdo_oe <= 1'b0;
      end
    end
  end

  AST_SDO_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo_oe); // R4
  AST_SDO_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> rd_frame); // R3
  AST_WRITE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (bit_cnt == CNT_FULL)); // R5
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int AW         = ADDR_W,
  parameter int DW         = DATA_W,
  parameter int NREG       = NUM_CFG,
  parameter int SLP_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  wr_req_t                  wr_req,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic [NREG-1:0][DW-1:0]  cfg_q,
  output logic                     sleep_pulse
);
  localparam int SLP_W = $clog2(SLP_CYCLES + 1);

  logic             swrst;
  logic [SLP_W-1:0] slp_cnt;

  assign swrst = wr_valid && (wr_req.addr == ADR_SWRST) && wr_req.data[DW-1];

  for (genvar i = 0; i < NREG; i++) begin : g_cfg
    localparam logic [AW-1:0] MY_ADDR = AW'(i + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[i] <= '0;
      else if (swrst)
        cfg_q[i] <= '0;
      else if (wr_valid && wr_req.addr == MY_ADDR)
        cfg_q[i] <= wr_req.data;
    end
  end

  // address 0 and unimplemented addresses return zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == AW'(i + 1)) rd_data = cfg_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      slp_cnt <= '0;
    else if (swrst)
      slp_cnt <= SLP_W'(SLP_CYCLES);
    else if (slp_cnt != '0)
      slp_cnt <= slp_cnt - 1'b1;
  end
  assign sleep_pulse = (slp_cnt != '0);

  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (cfg_q == '0)); // R6
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(cfg_q)); // R3
  AST_SLEEP_FROM_SWRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_pulse) |-> $past(swrst)); // R7
endmodule

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
  import ctlreg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   fmt_byte,
  input  logic [DW-1:0]   omode_byte,
  input  logic [DW-1:0]   tp_hi,
  input  logic [DW-1:0]   tp_lo,
  output logic            dcs_off,
  output logic            rand_en,
  output logic            twos_comp,
  output logic            sleep_mode,
  output logic            nap_ch1,
  output logic            nap_ch2,
  output logic [2:0]      drv_code,
  output logic            term_en,
  output logic            out_disable,
  output logic            test_pat_en,
  output logic [1:0]      lane_sel,
  output logic [2:0]      lane_onehot,
  output logic [2*DW-1:0] test_pattern
);
  assign dcs_off    = fmt_byte[FMT_DCS];
  assign rand_en    = fmt_byte[FMT_RAND];
  assign twos_comp  = fmt_byte[FMT_TWOS];
  assign sleep_mode = fmt_byte[FMT_SLEEP];
  assign nap_ch1    = ~fmt_byte[FMT_SLEEP] & fmt_byte[FMT_NAP1];
  assign nap_ch2    = ~fmt_byte[FMT_SLEEP] & fmt_byte[FMT_NAP2];

  assign drv_code    = omode_byte[OM_DRV_LSB +: 3];
  assign term_en     = omode_byte[OM_TERM];
  assign out_disable = omode_byte[OM_OFF];
  assign test_pat_en = omode_byte[OM_TEST];
  assign lane_sel    = omode_byte[1:0];

  always_comb begin
    unique case (lane_code_e'(lane_sel))
      LANES_TWO:  lane_onehot = 3'b010;
      LANES_FOUR: lane_onehot = 3'b100;
      LANES_ONE:  lane_onehot = 3'b001;
      default:    lane_onehot = 3'b000;
    endcase
  end

  assign test_pattern = {tp_hi, tp_lo};

  AST_SLEEP_OVERRIDES_NAP: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_mode |-> !(nap_ch1 || nap_ch2)); // R8
  AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_onehot)); // R9
  AST_RSVD_LANE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sel == 2'b11) |-> (lane_onehot == 3'b000)); // R9
endmodule

// File: rtl/ctlreg_spi_top.sv
module ctlreg_spi_top
  import ctlreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLP_CYCLES  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        sdi,
  output logic        sdo_oe,
  output logic        dcs_off,
  output logic        rand_en,
  output logic        twos_comp,
  output logic        sleep_mode,
  output logic        nap_ch1,
  output logic        nap_ch2,
  output logic        sw_sleep_pulse,
  output logic [2:0]  drv_code,
  output logic        term_en,
  output logic        out_disable,
  output logic        test_pat_en,
  output logic [1:0]  lane_sel,
  output logic [2:0]  lane_onehot,
  output logic [15:0] test_pattern
);
  logic                          wr_valid;
  wr_req_t                       wr_req;
  logic [ADDR_W-1:0]             rd_addr;
  logic [DATA_W-1:0]             rd_data;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;

  spi_frame_rx #(
    .SYNC_STAGES(SYNC_STAGES),
    .NBITS      (FRAME_BITS),
    .AW         (ADDR_W),
    .DW         (DATA_W)
  ) i_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sck     (sck),
    .sdi     (sdi),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_valid(wr_valid),
    .wr_req  (wr_req),
    .sdo_oe  (sdo_oe)
  );

  ctlreg_bank #(
    .AW        (ADDR_W),
    .DW        (DATA_W),
    .NREG      (NUM_CFG),
    .SLP_CYCLES(SLP_CYCLES)
  ) i_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_req     (wr_req),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .cfg_q      (cfg_q),
    .sleep_pulse(sw_sleep_pulse)
  );

  ctlreg_decode #(.DW(DATA_W)) i_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt_byte    (cfg_q[ADR_FMT-1]),
    .omode_byte  (cfg_q[ADR_OMODE-1]),
    .tp_hi       (cfg_q[ADR_TPHI-1]),
    .tp_lo       (cfg_q[ADR_TPLO-1]),
    .dcs_off     (dcs_off),
    .rand_en     (rand_en),
    .twos_comp   (twos_comp),
    .sleep_mode  (sleep_mode),
    .nap_ch1     (nap_ch1),
    .nap_ch2     (nap_ch2),
    .drv_code    (drv_code),
    .term_en     (term_en),
    .out_disable (out_disable),
    .test_pat_en (test_pat_en),
    .lane_sel    (lane_sel),
    .lane_onehot (lane_onehot),
    .test_pattern(test_pattern)
  );
endmodule

// File: tb/test_ctlreg_spi_top.sv
module test_ctlreg_spi_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int SLP        = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo_oe, dcs_off, rand_en, twos_comp, sleep_mode, nap_ch1, nap_ch2;
  logic sw_sleep_pulse, term_en, out_disable, test_pat_en;
  logic [2:0] drv_code, lane_onehot;
  logic [1:0] lane_sel;
  logic [15:0] test_pattern;

  int checks = 0, errors = 0;
  int exp_q[$];
  string req_q[$];
  int slp_seen = 0;
  int sdo_on_write = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlreg_spi_top #(.SLP_CYCLES(SLP)) i_ctlreg_spi_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo_oe(sdo_oe),
    .dcs_off(dcs_off), .rand_en(rand_en), .twos_comp(twos_comp),
    .sleep_mode(sleep_mode), .nap_ch1(nap_ch1), .nap_ch2(nap_ch2),
    .sw_sleep_pulse(sw_sleep_pulse), .drv_code(drv_code), .term_en(term_en),
    .out_disable(out_disable), .test_pat_en(test_pat_en), .lane_sel(lane_sel),
    .lane_onehot(lane_onehot), .test_pattern(test_pattern));

  always @(posedge clk) if (sw_sleep_pulse) slp_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: rebuilds the read byte from the line and compares with the scoreboard
  int  mon_cnt = 0;
  logic mon_rw = 1'b0;
  logic [7:0] mon_byte = '0;
  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      if (mon_cnt == 16 && mon_rw) begin
        int e;
        string r;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3: actual=%0h expected=<none>", mon_byte);
        end else begin
          e = exp_q.pop_front();
          r = req_q.pop_front();
          if (e >= 0) chk(r, {24'h0, mon_byte}, e[31:0]);
        end
      end
      mon_cnt = 0;
    end else begin
      if (mon_cnt == 0) mon_rw = sdi;
      if (mon_cnt >= 8 && mon_cnt < 16) mon_byte = {mon_byte[6:0], ~sdo_oe};
      if (!mon_rw && sdo_oe) sdo_on_write++;
      mon_cnt++;
    end
  end

  task automatic frame(input logic rw, input logic [6:0] addr, input logic [7:0] data,
                       input int nbits, input int exp_rd, input string req);
    logic [15:0] w;
    w = {rw, addr, data};
    if (rw && nbits == 16) begin
      exp_q.push_back(exp_rd);
      req_q.push_back(req);
    end
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = w[15-i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    frame(1'b0, a, d, 16, 0, "");
  endtask

  task automatic rd(input logic [6:0] a, input int exp, input string req);
    frame(1'b1, a, 8'hFF, 16, exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R12 during reset
    chk("R12 sdo in reset", {31'h0, sdo_oe}, 0);
    chk("R12 pattern in reset", {16'h0, test_pattern}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 lanes default", {29'h0, lane_onehot}, 32'h2);
    chk("R12 sleep", {30'h0, sleep_mode, sw_sleep_pulse}, 0);

    // R2 R8: format bits
    wr(7'h01, 8'hE0);
    chk("R8 dcs/rand/twos", {29'h0, dcs_off, rand_en, twos_comp}, 32'h7);
    chk("R8 power normal", {29'h0, sleep_mode, nap_ch1, nap_ch2}, 0);
    wr(7'h01, 8'h09);
    chk("R8 both naps", {29'h0, sleep_mode, nap_ch1, nap_ch2}, 32'h3);
    wr(7'h01, 8'h01);
    chk("R8 nap ch1 only", {29'h0, sleep_mode, nap_ch1, nap_ch2}, 32'h2);
    wr(7'h01, 8'h08);
    chk("R8 nap ch2 only", {29'h0, sleep_mode, nap_ch1, nap_ch2}, 32'h1);
    wr(7'h01, 8'h19);
    chk("R8 sleep overrides", {29'h0, sleep_mode, nap_ch1, nap_ch2}, 32'h4);

    // R9 output mode
    wr(7'h02, 8'hBD);
    chk("R9 drv_code", {29'h0, drv_code}, 32'h5);
    chk("R9 term/off/test", {29'h0, term_en, out_disable, test_pat_en}, 32'h7);
    chk("R9 4-lane", {29'h0, lane_onehot}, 32'h4);
    wr(7'h02, 8'h02);
    chk("R9 1-lane", {29'h0, lane_onehot}, 32'h1);
    wr(7'h02, 8'h03);
    chk("R9 reserved lanes", {27'h0, lane_sel, lane_onehot}, 32'h18);

    // R10 pattern
    wr(7'h03, 8'hA5);
    wr(7'h04, 8'h3C);
    chk("R10 pattern", {16'h0, test_pattern}, 32'hA53C);

    // R1 R3 reads, sdi all ones during data phase
    rd(7'h03, 8'hA5, "R3 read 03h");
    rd(7'h04, 8'h3C, "R1 read 04h");
    rd(7'h01, 8'h19, "R3 read 01h");
    rd(7'h02, 8'h03, "R3 read 02h");
    chk("R3 read left pattern", {16'h0, test_pattern}, 32'hA53C);
    chk("R4 released after read", {31'h0, sdo_oe}, 0);

    // R11 unimplemented addresses
    wr(7'h05, 8'hFF);
    wr(7'h7F, 8'h55);
    rd(7'h05, 0, "R11 read 05h");
    rd(7'h7F, 0, "R11 read 7Fh");
    chk("R11 no side effect", {16'h0, test_pattern}, 32'hA53C);

    // R5 aborted frames
    frame(1'b0, 7'h04, 8'h00, 12, 0, "");
    frame(1'b0, 7'h04, 8'h00, 15, 0, "");
    chk("R5 abort keeps pattern", {16'h0, test_pattern}, 32'hA53C);
    rd(7'h04, 8'h3C, "R5 read after abort");

    chk("R4 no drive on writes", sdo_on_write, 0);

    // R6 R7 software reset
    s0 = slp_seen;
    wr(7'h00, 8'h7F);
    chk("R6 D7=0 no effect", {16'h0, test_pattern}, 32'hA53C);
    chk("R7 no pulse for D7=0", slp_seen - s0, 0);
    s0 = slp_seen;
    wr(7'h00, 8'h80);
    chk("R6 pattern cleared", {16'h0, test_pattern}, 0);
    chk("R6 format cleared", {28'h0, sleep_mode, dcs_off, rand_en, twos_comp}, 0);
    chk("R6 lanes default", {29'h0, lane_onehot}, 32'h2);
    chk("R7 pulse width", slp_seen - s0, SLP);
    rd(7'h00, -1, "R6 read 00h");
    rd(7'h02, 0, "R6 read 02h cleared");

    // R12 hardware reset
    wr(7'h03, 8'h77);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R12 hw reset clears", {16'h0, test_pattern}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 all reads scored", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule